// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The block follows a chain of command packets held in system memory and streams their payload words to a downstream command consumer. Each node starts with one header word carrying a payload length and the address of the following node; the payload words sit directly after the header. The walker fetches the header, forwards the payload, adds the node's cost to a running total, and moves on to the next node. It stops when a next-node address carries the end marker, or when it detects that the chain has looped back on itself.

Software or a DMA front end starts a walk with a one-cycle `start` pulse and a start address. Memory is reached through a request/response port with one read outstanding at a time. The downstream side is a valid/ready word stream. While the consumer holds back, no new memory read is issued. The walk finishes with a one-cycle `done` pulse. `loop_det` tells a runaway chain apart from a normal end, and `cost` holds the summed cycle cost of every node visited.

Top module: `chain_walker`

## Requirements
- R1: After reset, busy, done, loop_det, cmd_valid and mem_req_valid are low and cost is zero.
- R2: Each node is fetched at its address with bits 1:0 cleared and every bit from 21 upward dropped. The header read comes first, then the payload reads in order, one word apart, wrapping within the 2 MB space.
- R3: Header bits 31:24 give the payload length and bits 23:0 give the next node address. Exactly that many following words reach cmd_data, in memory order. A length of 0 forwards nothing.
- R4: No memory request is issued while cmd_ready is low or a forwarded word is still waiting on the output.
- R5: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_data stays unchanged.
- R6: Each node adds 10 to cost, plus 5 + length when its length is non-zero. cost clears when a walk starts and does not change between walks.
- R7: A next address with bit 23 set ends the walk. done is high for exactly one cycle, after the last payload word has been accepted downstream. A start address with bit 23 set ends at once with no fetch and a cost of 0.
- R8: Loop guard. A checkpoint address starts as the start address and a checkpoint count starts at 32. After node k (counting from 0), if the next address equals the checkpoint, the walk ends with loop_det set. Otherwise, if k equals the count, the checkpoint becomes that next address and the count doubles. loop_det clears on the next start.
- R9: A start pulse that arrives while busy is high is ignored. The running walk continues unchanged and produces one done.
- R10: Only bits 23:0 of start_addr are used. They give both the first node address and the initial checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a walk (taken only when idle) |
| start_addr | input | 32 | Address of the first node; bits 23:0 used |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| loop_det | output | 1 | Last walk was stopped by the loop guard |
| cost | output | 32 | Accumulated cycle cost of the current or last walk |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 21 | Byte address of the word to read, word aligned |
| mem_rsp_valid | input | 1 | Read data valid (one per accepted request) |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Payload word available downstream |
| cmd_ready | input | 1 | Downstream accepts the word |
| cmd_data | output | 32 | Payload word |

## Verification
A wrong remaining-length count or a wrong fetch pointer shows up on the very next memory request, as an unexpected address. It then shows on the downstream stream as a missing, extra or reordered word, which the scoreboard catches at the first mismatched word. A corrupted cost term or next-pointer capture only shows when done rises: as a wrong total, an early or late end, or a spurious loop_det. A broken loop guard may run for dozens of nodes before the divergence becomes visible. Backpressure faults show in the cycle where a request goes out while the output word is blocked.

// File: rtl/chain_pkg.sv
package chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HREQ,
    ST_HWAIT,
    ST_PREQ,
    ST_PWAIT,
    ST_NEXT,
    ST_FIN
  } walk_state_t;

endpackage

// File: rtl/chain_rst_sync.sv
module chain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/chain_out_slot.sv
module chain_out_slot #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data
);

  logic              valid_q, valid_d;
  logic [WORD_W-1:0] data_q;
  logic              data_en;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready) valid_d = 1'b0;
    if (load)             valid_d = 1'b1;
  end

  assign data_en = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (data_en) data_q <= din;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

endmodule

// File: rtl/chain_cost_acc.sv
module chain_cost_acc #(
  parameter int COST_W    = 32,
  parameter int LEN_W     = 8,
  parameter int NODE_COST = 10,
  parameter int PAY_COST  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [LEN_W-1:0]  len,
  output logic [COST_W-1:0] cost
);

  logic [COST_W-1:0] cost_q, cost_d;
  logic [COST_W-1:0] amt;

  always_comb begin
    amt = COST_W'(NODE_COST);
    if (len != '0) amt = amt + COST_W'(PAY_COST) + COST_W'(len);
  end

  always_comb begin
    cost_d = cost_q;
    if (clr)      cost_d = '0;
    else if (add) cost_d = cost_q + amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cost_q <= '0;
    else        cost_q <= cost_d;
  end

  assign cost = cost_q;

endmodule

// File: rtl/chain_loop_guard.sv
module chain_loop_guard #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 32,
  parameter int CKPT_FIRST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic              step,
  input  logic [ADDR_W-1:0] next_addr,
  output logic              hit
);

  logic [ADDR_W-1:0] ckpt_q, ckpt_d;
  logic [CNT_W-1:0]  node_q, node_d;
  logic [CNT_W-1:0]  lim_q, lim_d;
  logic              move_ckpt;

  assign hit       = step && (next_addr == ckpt_q);
  assign move_ckpt = step && (node_q == lim_q);

  always_comb begin
    ckpt_d = ckpt_q;
    node_d = node_q;
    lim_d  = lim_q;
    if (init) begin
      ckpt_d = init_addr;
      node_d = '0;
      lim_d  = CNT_W'(CKPT_FIRST);
    end else if (step) begin
      node_d = node_q + 1'b1;
      if (move_ckpt) begin
        ckpt_d = next_addr;
        lim_d  = {lim_q[CNT_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckpt_q <= '0;
      node_q <= '0;
      lim_q  <= CNT_W'(CKPT_FIRST);
    end else begin
      ckpt_q <= ckpt_d;
      node_q <= node_d;
      lim_q  <= lim_d;
    end
  end

endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 8,
  parameter int MEM_AW     = 21,
  parameter int COST_W     = 32,
  parameter int CNT_W      = 32,
  parameter int CKPT_FIRST = 32,
  parameter int NODE_COST  = 10,
  parameter int PAY_COST   = 5,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic              loop_det,
  output logic [COST_W-1:0] cost,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_data
);

  localparam int END_BIT    = ADDR_W - 1;
  localparam int LEN_LSB    = WORD_W - LEN_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int ALIGN_W    = $clog2(WORD_BYTES);
  localparam logic [MEM_AW-1:0] STRIDE = MEM_AW'(WORD_BYTES);

  logic rst_n_int;

  walk_state_t       state_q, state_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic [MEM_AW-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              loop_q, loop_d;
  logic              done_q, done_d;

  logic              can_issue, req_fire, rsp_hdr, rsp_pay;
  logic              start_take, node_step, loop_hit;
  logic [LEN_W-1:0]  hdr_len;
  logic [ADDR_W-1:0] hdr_next;
  logic              start_hi_unused;

  chain_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign start_hi_unused = ^start_addr[WORD_W-1:ADDR_W];

  assign hdr_len  = mem_rsp_data[WORD_W-1:LEN_LSB];
  assign hdr_next = mem_rsp_data[ADDR_W-1:0];

  assign can_issue     = cmd_ready && !cmd_valid;
  assign mem_req_valid = ((state_q == ST_HREQ) || (state_q == ST_PREQ)) && can_issue;
  assign mem_req_addr  = {ptr_q[MEM_AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_hdr       = (state_q == ST_HWAIT) && mem_rsp_valid;
  assign rsp_pay       = (state_q == ST_PWAIT) && mem_rsp_valid;
  assign start_take    = (state_q == ST_IDLE) && start;
  assign node_step     = (state_q == ST_NEXT);

  always_comb begin
    state_d = state_q;
    nxt_d   = nxt_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    loop_d  = loop_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          loop_d = 1'b0;
          ptr_d  = start_addr[MEM_AW-1:0];
          if (start_addr[END_BIT]) state_d = ST_FIN;
          else                     state_d = ST_HREQ;
        end
      end
      ST_HREQ: begin
        if (req_fire) state_d = ST_HWAIT;
      end
      ST_HWAIT: begin
        if (mem_rsp_valid) begin
          nxt_d = hdr_next;
          rem_d = hdr_len;
          ptr_d = ptr_q + STRIDE;
          if (hdr_len == '0) state_d = ST_NEXT;
          else               state_d = ST_PREQ;
        end
      end
      ST_PREQ: begin
        if (req_fire) state_d = ST_PWAIT;
      end
      ST_PWAIT: begin
        if (mem_rsp_valid) begin
          rem_d = rem_q - 1'b1;
          ptr_d = ptr_q + STRIDE;
          if (rem_q == LEN_W'(1)) state_d = ST_NEXT;
          else                    state_d = ST_PREQ;
        end
      end
      ST_NEXT: begin
        if (loop_hit) begin
          loop_d  = 1'b1;
          state_d = ST_FIN;
        end else if (nxt_q[END_BIT]) begin
          state_d = ST_FIN;
        end else begin
          ptr_d   = nxt_q[MEM_AW-1:0];
          state_d = ST_HREQ;
        end
      end
      ST_FIN: begin
        if (!cmd_valid) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      nxt_q   <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      loop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      loop_q  <= loop_d;
      done_q  <= done_d;
    end
  end

  chain_out_slot #(.WORD_W(WORD_W)) u_slot (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (rsp_pay),
    .din   (mem_rsp_data),
    .ready (cmd_ready),
    .valid (cmd_valid),
    .data  (cmd_data)
  );

  chain_cost_acc #(
    .COST_W    (COST_W),
    .LEN_W     (LEN_W),
    .NODE_COST (NODE_COST),
    .PAY_COST  (PAY_COST)
  ) u_cost (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (start_take),
    .add   (rsp_hdr),
    .len   (hdr_len),
    .cost  (cost)
  );

  chain_loop_guard #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .CKPT_FIRST (CKPT_FIRST)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .init      (start_take),
    .init_addr (start_addr[ADDR_W-1:0]),
    .step      (node_step),
    .next_addr (nxt_q),
    .hit       (loop_hit)
  );

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign loop_det = loop_q;

endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int WORD_W = 32,
  parameter int COST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              loop_det,
  input logic [COST_W-1:0] cost,
  input logic              mem_req_valid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [WORD_W-1:0] cmd_data
);

  a_r4_no_fetch_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_req_valid);

  a_r4_no_fetch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !mem_req_valid);

  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_cost_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(cost));

  a_r8_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(loop_det));

endmodule

bind chain_walker chain_walker_chk #(
  .WORD_W (WORD_W),
  .COST_W (COST_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .loop_det      (loop_det),
  .cost          (cost),
  .mem_req_valid (mem_req_valid),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_data      (cmd_data)
);

// File: tb/chain_walker_tb_top.sv
module chain_walker_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic        busy, done, loop_det;
  logic [31:0] cost;
  logic        mem_req_valid, mem_req_ready;
  logic [20:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_data;

  chain_walker dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_addr    (start_addr),
    .busy          (busy),
    .done          (done),
    .loop_det      (loop_det),
    .cost          (cost),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_data      (cmd_data)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  int mode   = 0;
  int done_cnt, stall_viol, width_viol;
  bit prev_done;

  logic [31:0] mem [int];
  logic [31:0] exp_fetch[$];
  logic [31:0] exp_pay[$];
  logic [31:0] exp_cost;
  bit          exp_loop;

  int          rsp_wait = 0;
  logic [31:0] rsp_addr = '0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    int k;
    k = int'(a >> 2);
    if (mem.exists(k)) return mem[k];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Expected walk computed from the requirements (R2, R3, R6, R7, R8, R10)
  task automatic model(input logic [31:0] sa);
    logic [31:0] a, ck, ckc, n, f, h, nx, fa, len;
    int guard;
    exp_fetch.delete();
    exp_pay.delete();
    a = sa & 32'h00FF_FFFF;
    ck = a; ckc = 32; n = 0;
    exp_cost = 0; exp_loop = 0; guard = 0;
    while (!a[23] && guard < 5000) begin
      guard++;
      f = a & 32'h001F_FFFC;
      exp_fetch.push_back(f);
      h = rd(f);
      len = {24'h0, h[31:24]};
      nx = {8'h0, h[23:0]};
      exp_cost = exp_cost + 10 + ((len != 0) ? (5 + len) : 0);
      for (int i = 1; i <= int'(len); i++) begin
        fa = (f + 4*i) & 32'h001F_FFFC;
        exp_fetch.push_back(fa);
        exp_pay.push_back(rd(fa));
      end
      if (nx == ck) begin
        exp_loop = 1;
        break;
      end
      if (n == ckc) begin
        ck = nx;
        ckc = ckc * 2;
      end
      n++;
      a = nx;
    end
  endtask

  // Environment: memory responder, downstream ready, scoreboard monitor
  initial begin
    cmd_ready     = 1'b0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      case (mode)
        0:       cmd_ready = 1'b1;
        1:       cmd_ready = (cyc % 3) != 0;
        default: cmd_ready = (cyc % 16) >= 10;
      endcase
      mem_req_ready = (mode == 1) ? ((cyc % 2) == 1) : 1'b1;
      mem_rsp_valid = 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(rsp_addr);
        end
      end
      #1;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_fetch.size() == 0) begin
          chk(1'b0, "R2", "unexpected fetch", {11'h0, mem_req_addr}, 32'h0);
        end else begin
          logic [31:0] ef;
          ef = exp_fetch.pop_front();
          chk({11'h0, mem_req_addr} == ef, "R2", "fetch address", {11'h0, mem_req_addr}, ef);
        end
        rsp_addr = {11'h0, mem_req_addr};
        rsp_wait = (mode == 1) ? 3 : 2;
      end
      if (mem_req_valid && (!cmd_ready || cmd_valid)) stall_viol++;
      if (cmd_valid && cmd_ready) begin
        if (exp_pay.size() == 0) begin
          chk(1'b0, "R3", "unexpected payload word", cmd_data, 32'h0);
        end else begin
          logic [31:0] ep;
          ep = exp_pay.pop_front();
          chk(cmd_data == ep, "R3", "payload word", cmd_data, ep);
        end
      end
      if (done) begin
        done_cnt++;
        if (prev_done) width_viol++;
      end
      prev_done = done;
    end
  end

  task automatic run(input logic [31:0] sa, input int m, input bit poke);
    int t;
    model(sa);
    mode = m;
    done_cnt = 0; stall_viol = 0; width_viol = 0;
    @(negedge clk);
    start = 1'b1; start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy == 1'b1, "R9", "busy during walk", {31'h0, busy}, 32'h1);
      start = 1'b1; start_addr = 32'h0080_0000;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk);
      #3;
      t++;
    end
    repeat (4) @(negedge clk);
    #3;
    chk(done_cnt == 1, poke ? "R9" : "R7", "done pulses", done_cnt, 1);
    chk(width_viol == 0, "R7", "done wider than one cycle", width_viol, 0);
    chk(cost == exp_cost, "R6", "cost", cost, exp_cost);
    chk(loop_det == exp_loop, "R8", "loop flag", {31'h0, loop_det}, {31'h0, exp_loop});
    chk(exp_pay.size() == 0, "R3", "payload words left", exp_pay.size(), 0);
    chk(exp_fetch.size() == 0, "R2", "fetches left", exp_fetch.size(), 0);
    chk(stall_viol == 0, "R4", "request under backpressure", stall_viol, 0);
    chk(busy == 1'b0, "R7", "idle after done", {31'h0, busy}, 32'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    start_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", {31'h0, busy}, 32'h0);
    chk(done == 1'b0, "R1", "done", {31'h0, done}, 32'h0);
    chk(loop_det == 1'b0, "R1", "loop_det", {31'h0, loop_det}, 32'h0);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid", {31'h0, cmd_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk(cost == 32'h0, "R1", "cost", cost, 32'h0);

    // three-node chain: lengths 2, 0, 3, then end marker
    mem[32'h1000 >> 2] = {8'd2, 24'h001100};
    mem[32'h1004 >> 2] = 32'hA000_0001;
    mem[32'h1008 >> 2] = 32'hA000_0002;
    mem[32'h1100 >> 2] = {8'd0, 24'h001200};
    mem[32'h1200 >> 2] = {8'd3, 24'h800000};
    mem[32'h1204 >> 2] = 32'hB000_0001;
    mem[32'h1208 >> 2] = 32'hB000_0002;
    mem[32'h120C >> 2] = 32'hB000_0003;
    run(32'h0000_1000, 0, 1'b0);   // R3 R6 R7 plain stream
    run(32'h0000_1000, 1, 1'b0);   // R4 R5 toggling ready
    run(32'h0000_1000, 2, 1'b0);   // R4 R5 long stalls
    run(32'h0000_1000, 0, 1'b1);   // R9 start ignored while busy

    // R7: start address already carries the end marker
    run(32'h0080_1000, 0, 1'b0);

    // R10 and R2: upper start bits dropped, bit 21 dropped for fetch
    mem[32'h0100 >> 2] = {8'd1, 24'h800000};
    mem[32'h0104 >> 2] = 32'hC0DE_0001;
    run(32'hAB20_0100, 0, 1'b0);

    // R8: node pointing back at the start address
    mem[32'h0300 >> 2] = {8'd1, 24'h000300};
    mem[32'h0304 >> 2] = 32'hD000_0001;
    run(32'h0000_0300, 0, 1'b0);

    // R8: ring that excludes the start, caught after a checkpoint move
    for (int i = 0; i < 40; i++) begin
      logic [23:0] nx;
      nx = (i == 39) ? 24'(32'h4000 + 35*16) : 24'(32'h4000 + (i+1)*16);
      mem[(32'h4000 + i*16) >> 2] = {8'd0, nx};
    end
    run(32'h0000_4000, 1, 1'b0);

    finish_run();
  end

endmodule